// File: doc/BRIEF.md
# Interrupt Source Target Register Bank

This block is the register file of one interrupt-controller domain. For every interrupt source it holds a configuration word and a target word, and it serves 32-bit word reads and writes from a simple register bus. Source numbers run from 1 to `NUM_SRC-1`. Configuration word `i` sits at `CFG_BASE + 4*(i-1)` and target word `i` sits at `TGT_BASE + 4*(i-1)`.

A source's target word can be seen only while that source is live in this domain. A source is live when its configuration does not hand it to a child domain and its mode field is not the "off" code. Otherwise the target word reads as zero and ignores writes. The stored value is kept while the source is not live, and it becomes visible again once the source is re-enabled. A delivery-mode input picks between direct delivery and message delivery, and each mode keeps a different set of target fields.

Read data is registered and returns one cycle after the request. Only whole-word accesses are accepted.

Top module: `irq_target_bank`

## Requirements
- R1: After reset, every configuration and target word reads zero and `rd_valid` is low.
- R2: An access with `req_size` other than 2 (the 4-byte code) is rejected. A read returns zero, and a write changes no stored word.
- R3: A configuration word keeps only bit 10 (handed to a child domain) and bits 2:0 (mode field). All other bits read zero.
- R4: Source `i` is live exactly when configuration bit 10 is 0 and the mode field is non-zero. Mode 0 means off.
- R5: A read of a target word whose source is not live returns zero, whatever value is stored.
- R6: A write to a target word whose source is not live leaves the stored value unchanged.
- R7: With `msi_mode`=0 (direct), a target write keeps bits 31:18 and 7:0, clears bits 17:8, and stores a priority (bits 7:0) of zero as 1.
- R8: With `msi_mode`=1 (message), a target write keeps bits 31:12 and 10:0. Bit 11 always reads zero.
- R9: Only aligned addresses inside the two windows of `NUM_SRC-1` words are mapped. All other addresses read zero and ignore writes, and source 0 never holds state.
- R10: The liveness check uses the configuration as it stands at the time of the access. A target value written while live reads back unchanged after the source is turned off and then turned on again.
- R11: `rd_valid` is high in the cycle after a read request, and only then, with `rd_data` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code; 2 = 4 bytes |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| msi_mode | input | 1 | Delivery mode: 0 direct, 1 message |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |

## Verification
On every cycle, the assertions check these properties:
- Configuration words and target words never hold bits outside their kept fields.
- Source 0 stays empty.
- Rejected and not-live writes leave storage untouched.
- Not-live and rejected reads answer zero.
- A direct-mode write never leaves a zero priority.

The bench sweeps every mode code and delegation setting for every source in both delivery modes, and checks the exact stored values. Only these bench scenarios can show three things: the exact field masking, the return of a stale value after re-enabling, and the exact address boundaries.

// File: rtl/irq_target_bank.sv
module irq_target_bank #(
  parameter int NUM_SRC  = 8,
  parameter int ADDR_W   = 12,
  parameter int CFG_BASE = 'h100,
  parameter int TGT_BASE = 'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              msi_mode,
  output logic              rd_valid,
  output logic [31:0]       rd_data
);
  localparam int          IW       = $clog2(NUM_SRC);
  localparam int          WORDS    = NUM_SRC - 1;
  localparam logic [31:0] CFG_END  = 32'(CFG_BASE + 4 * WORDS);
  localparam logic [31:0] TGT_END  = 32'(TGT_BASE + 4 * WORDS);
  localparam logic [31:0] CFG_KEEP = 32'h0000_0407;
  localparam logic [31:0] MSI_KEEP = 32'hFFFF_F7FF;

  logic [NUM_SRC-1:0][31:0] cfg_q;
  logic [NUM_SRC-1:0][31:0] tgt_q;

  logic [31:0]   a32, cfg_off, tgt_off;
  logic          word_ok, cfg_hit, tgt_hit, tgt_live;
  logic [IW-1:0] cfg_idx, tgt_idx;
  logic [31:0]   tgt_wval, rd_next;

  assign a32     = 32'(req_addr);
  assign word_ok = (req_size == 2'd2);
  assign cfg_off = a32 - 32'(CFG_BASE);
  assign tgt_off = a32 - 32'(TGT_BASE);
  assign cfg_hit = (a32 >= 32'(CFG_BASE)) && (a32 < CFG_END) && (a32[1:0] == 2'b00);
  assign tgt_hit = (a32 >= 32'(TGT_BASE)) && (a32 < TGT_END) && (a32[1:0] == 2'b00);
  assign cfg_idx = IW'(cfg_off[31:2] + 30'd1);
  assign tgt_idx = IW'(tgt_off[31:2] + 30'd1);

  function automatic logic live(input logic [IW-1:0] i, input logic [31:0] c);
    return (i != '0) && (32'(i) < 32'(NUM_SRC)) && !c[10] && (c[2:0] != 3'd0);
  endfunction

  assign tgt_live = live(tgt_idx, cfg_q[tgt_idx]);

  assign tgt_wval = msi_mode ? (req_wdata & MSI_KEEP)
                             : {req_wdata[31:18], 10'd0,
                                (req_wdata[7:0] == 8'd0) ? 8'd1 : req_wdata[7:0]};

  always_comb begin
    rd_next = '0;
    if (word_ok) begin
      if (cfg_hit)                  rd_next = cfg_q[cfg_idx];
      else if (tgt_hit && tgt_live) rd_next = tgt_q[tgt_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      tgt_q <= '0;
    end else if (req_valid && req_write && word_ok) begin
      if (cfg_hit)                  cfg_q[cfg_idx] <= req_wdata & CFG_KEEP;
      else if (tgt_hit && tgt_live) tgt_q[tgt_idx] <= tgt_wval;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= req_valid && !req_write;
      rd_data  <= (req_valid && !req_write) ? rd_next : '0;
    end
  end
endmodule

// File: rtl/irq_target_bank_chk.sv
module irq_target_bank_chk #(
  parameter int NUM_SRC  = 8,
  parameter int ADDR_W   = 12,
  parameter int TGT_BASE = 'h400
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_write,
  input logic [1:0]               req_size,
  input logic [ADDR_W-1:0]        req_addr,
  input logic                     msi_mode,
  input logic                     rd_valid,
  input logic [31:0]              rd_data,
  input logic [NUM_SRC-1:0][31:0] cfg_q,
  input logic [NUM_SRC-1:0][31:0] tgt_q
);
  localparam int IW = $clog2(NUM_SRC);

  logic [31:0]   off;
  logic          hit, dead;
  logic [IW-1:0] idx;

  assign off  = 32'(req_addr) - 32'(TGT_BASE);
  assign hit  = (32'(req_addr) >= 32'(TGT_BASE)) && (off < 32'(4 * (NUM_SRC - 1))) &&
                (off[1:0] == 2'b00);
  assign idx  = IW'(off[31:2] + 30'd1);
  assign dead = cfg_q[idx][10] || (cfg_q[idx][2:0] == 3'd0);

  // R11
  rd_valid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && !req_write));

  // R2
  short_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size != 2'd2) |=> (rd_data == 32'd0));

  // R2
  short_write_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_size != 2'd2) |=> ($stable(cfg_q) && $stable(tgt_q)));

  // R5
  dead_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && hit && dead) |=> (rd_data == 32'd0));

  // R6
  dead_write_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && hit && dead) |=> $stable(tgt_q));

  // R7
  direct_prio_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_size == 2'd2 && hit && !dead && !msi_mode)
      |=> (tgt_q[$past(idx)][7:0] != 8'd0));

  // R9
  src_zero_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[0] == 32'd0) && (tgt_q[0] == 32'd0));

  for (genvar g = 1; g < NUM_SRC; g++) begin : g_inv
    // R3
    cfg_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[g][31:11] == 21'd0) && (cfg_q[g][9:3] == 7'd0));
    // R8
    tgt_bit11_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_q[g][11] == 1'b0);
  end
endmodule

bind irq_target_bank irq_target_bank_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .TGT_BASE(TGT_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_size(req_size), .req_addr(req_addr), .msi_mode(msi_mode),
  .rd_valid(rd_valid), .rd_data(rd_data), .cfg_q(cfg_q), .tgt_q(tgt_q)
);

// File: tb/irq_target_bank_tb.sv
module irq_target_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 8;
  localparam int AW   = 12;
  localparam int CB   = 'h100;
  localparam int TB_A = 'h400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, msi_mode = 1'b0;
  logic [1:0]    req_size = 2'd2;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rd_valid;
  logic [31:0]   rd_data;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_cfg [N];
  logic [31:0] exp_tgt [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_target_bank #(.NUM_SRC(N), .ADDR_W(AW), .CFG_BASE(CB), .TGT_BASE(TB_A)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .msi_mode(msi_mode), .rd_valid(rd_valid), .rd_data(rd_data));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(addr); req_wdata = d; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_size = 2'd2;
    chk("R11 no rd_valid after write", 32'(rd_valid), 32'd0);
  endtask

  task automatic rd(input int addr, output logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(addr); req_size = sz;
    @(negedge clk);
    req_valid = 1'b0; req_size = 2'd2;
    chk("R11 rd_valid after read", 32'(rd_valid), 32'd1);
    d = rd_data;
  endtask

  function automatic logic is_live(input logic [31:0] c);
    return !c[10] && (c[2:0] != 3'd0);
  endfunction

  function automatic logic [31:0] tmask(input logic [31:0] d, input logic m);
    logic [31:0] p;
    if (m) return d & 32'hFFFF_F7FF;
    p = d & 32'hFFFC_00FF;
    if (d[7:0] == 8'd0) p = p | 32'd1;
    return p;
  endfunction

  function automatic logic [31:0] pat(input int k);
    logic [31:0] v;
    v = 32'(k + 1) * 32'h9E37_79B9;
    if (k % 5 == 0) v[7:0] = 8'd0;
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int k;
    for (int i = 0; i < N; i++) begin exp_cfg[i] = '0; exp_tgt[i] = '0; end
    #(CLK_PERIOD * 3);
    @(negedge clk);
    chk("R1 rd_valid in reset", 32'(rd_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd_valid after reset", 32'(rd_valid), 32'd0);
    for (int i = 1; i < N; i++) begin
      rd(CB + 4*(i-1), d);   chk("R1 cfg reset", d, 32'd0);
      rd(TB_A + 4*(i-1), d); chk("R1 tgt reset", d, 32'd0);
    end

    // R4 R5 R6 R7 R8: full sweep of mode codes and delegation per source
    k = 0;
    for (int m = 0; m < 2; m++) begin
      msi_mode = m[0];
      for (int s = 1; s < N; s++) begin
        for (int c = 0; c < 16; c++) begin
          logic [31:0] cv, tv;
          cv = 32'hFFFF_FBF8 | (32'(c >> 3) << 10) | 32'(c & 7);
          wr(CB + 4*(s-1), cv);
          exp_cfg[s] = cv & 32'h0000_0407;
          rd(CB + 4*(s-1), d);
          chk("R3 cfg fields", d, exp_cfg[s]);
          tv = pat(k); k++;
          wr(TB_A + 4*(s-1), tv);
          if (is_live(exp_cfg[s])) exp_tgt[s] = tmask(tv, m[0]);
          rd(TB_A + 4*(s-1), d);
          if (is_live(exp_cfg[s])) chk(m ? "R8 msi target" : "R7 direct target", d, exp_tgt[s]);
          else                     chk("R5 R6 dead target", d, 32'd0);
        end
      end
    end

    // R10: stale value returns after re-enable
    msi_mode = 1'b1;
    wr(CB + 8, 32'd1); exp_cfg[3] = 32'd1;
    wr(TB_A + 8, 32'hABCD_E123); exp_tgt[3] = tmask(32'hABCD_E123, 1'b1);
    wr(CB + 8, 32'h401);
    rd(TB_A + 8, d); chk("R10 delegated reads zero", d, 32'd0);
    wr(TB_A + 8, 32'h1111_1111);
    wr(CB + 8, 32'd0);
    rd(TB_A + 8, d); chk("R10 off reads zero", d, 32'd0);
    wr(TB_A + 8, 32'h2222_2222);
    wr(CB + 8, 32'd5);
    rd(TB_A + 8, d); chk("R10 stale value back", d, exp_tgt[3]);

    // R2: non-word accesses
    wr(CB + 4, 32'd2);
    wr(TB_A + 4, 32'h5555_0055); exp_tgt[2] = tmask(32'h5555_0055, 1'b1);
    for (int z = 0; z < 4; z++) begin
      if (z == 2) continue;
      wr(TB_A + 4, 32'hFFFF_FFFF, 2'(z));
      wr(CB + 4, 32'h0, 2'(z));
      rd(TB_A + 4, d, 2'(z)); chk("R2 short read zero", d, 32'd0);
      rd(CB + 4, d, 2'(z));   chk("R2 short cfg read zero", d, 32'd0);
    end
    rd(CB + 4, d);   chk("R2 cfg unchanged", d, 32'd2);
    rd(TB_A + 4, d); chk("R2 tgt unchanged", d, exp_tgt[2]);

    // R9: out-of-window and unaligned addresses
    for (int s = 1; s < N; s++) wr(CB + 4*(s-1), 32'd1);
    for (int s = 1; s < N; s++) exp_cfg[s] = 32'd1;
    wr(TB_A + 4*(N-1), 32'hDEAD_BEEF);
    wr(TB_A - 4, 32'hDEAD_BEEF);
    wr(TB_A + 2, 32'hDEAD_BEEF);
    wr(CB + 4*(N-1), 32'h7);
    wr(CB - 4, 32'h7);
    rd(TB_A + 4*(N-1), d); chk("R9 past window", d, 32'd0);
    rd(TB_A - 4, d);       chk("R9 source 0 slot", d, 32'd0);
    rd(TB_A + 2, d);       chk("R9 unaligned", d, 32'd0);
    rd(CB + 4*(N-1), d);   chk("R9 cfg past window", d, 32'd0);
    for (int s = 1; s < N; s++) begin
      rd(CB + 4*(s-1), d);   chk("R9 cfg intact", d, exp_cfg[s]);
      rd(TB_A + 4*(s-1), d); chk("R9 tgt intact", d, exp_tgt[s]);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule